// File: doc/BRIEF.md
# Comparator Mismatch Self-Test Sequencer

This block proves that an equality comparator watching a group of bus signals can detect a difference. In normal use the comparator sees a live signal group on one side and a reference group on the other. Both groups are expected to stay inactive, so any mismatch points to a fault. A self-test is launched with a start pulse. The block then injects a walking-one vector into the live side of the comparator, advancing one signal position per clock. It needs a mismatch on every pattern.

A healthy comparator produces a mismatch for each of the six patterns, and the run then ends without any error. If the comparator reports equality for any pattern, the block stops the run at once. It sets a sticky error flag and emits a one-cycle error pulse for an error-handling unit. In both cases a one-cycle done strobe marks the end of the run. The comparator is part of the block, so the whole path can be exercised on its own. The surrounding logic holds the reference side at zero during a test. Driving a nonzero value there is how a stuck comparator is emulated.

Top module: `mismatch_selftest`

## Requirements
- R1: `mismatch` is high in the same cycle exactly when (`liveBus` XOR `testVec`) differs from `refBus`; it is purely combinational.
- R2: A `start` sampled high at a clock edge while idle makes `busy` high from that edge. One pattern is applied per cycle, so a run with no failure keeps `busy` high for exactly 6 cycles.
- R3: While `busy` is high, `testVec` has exactly one bit set.
- R4: The set bit is bit 0 in the first busy cycle and moves up by one position each busy cycle, reaching bit 5 in the sixth.
- R5: A busy cycle in which `mismatch` is low ends the run at the next edge. At that edge `busy` falls, `stErr` is set, and `errPulse` is high for exactly one cycle. No later pattern is applied.
- R6: A run in which every pattern produces a mismatch raises no `errPulse` and leaves `stErr` unchanged.
- R7: While `busy` is low, `testVec` is all zeros.
- R8: `done` is high for exactly one cycle, immediately after the last applied pattern, whether the run was complete or stopped early. `busy` is low in that cycle.
- R9: `stErr` holds until reset or until `clrErr` is sampled high. A new error and a clear at the same edge leave it set.
- R10: `start` sampled while `busy` is high has no effect on the pattern order or run length.
- R11: After reset, `busy`, `done`, `stErr`, `errPulse` and `testVec` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Self-test launch request, honoured only when idle |
| clrErr | input | 1 | Clears the sticky self-test error flag |
| liveBus | input | 6 | Monitored signal group, live side of the comparator |
| refBus | input | 6 | Reference side of the comparator, held at zero during a test |
| testVec | output | 6 | Injected fault vector XORed into the live side |
| mismatch | output | 1 | Comparator result, high on any difference |
| busy | output | 1 | Self-test run in progress |
| done | output | 1 | One-cycle strobe at the end of a run |
| stErr | output | 1 | Sticky self-test failure flag |
| errPulse | output | 1 | One-cycle error indication for the error handler |

## Verification
Some properties are checked on every cycle: the single set bit during a run, the one-position advance between consecutive busy cycles, the zero vector when idle, the early stop with flag and pulse after an equal compare, the single-cycle done and error strobes, and the hold-or-clear behaviour of the sticky flag. Other behaviours only show up in the bench's scenarios. These are the exact run length of six, the rejection of a start issued mid-run, the position at which an emulated stuck comparator halts the walk (first, middle and last position), and the outcome when set and clear meet at the same edge. The bench's reference model follows every output on every cycle through all of them.

// File: rtl/mst_pkg.sv
package mst_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mstState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // place the one at position 0
    logic advance;  // move the one up by a single position
    logic clear;    // return the injection vector to zero
  } mstStrobe_t;

endpackage

// File: rtl/mst_compare.sv
module mst_compare #(
  parameter int NUM_SIG = 6
) (
  input  logic [NUM_SIG-1:0] sideA,
  input  logic [NUM_SIG-1:0] sideB,
  output logic               mismatch
);

  logic [NUM_SIG-1:0] bitDiff;

  for (genvar i = 0; i < NUM_SIG; i++) begin : g_bit
    assign bitDiff[i] = sideA[i] ^ sideB[i];
  end

  assign mismatch = |bitDiff;

endmodule

// File: rtl/mst_datapath.sv
module mst_datapath
  import mst_pkg::*;
#(
  parameter int NUM_SIG = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  mstStrobe_t         strobe,
  input  logic [NUM_SIG-1:0] liveBus,
  input  logic [NUM_SIG-1:0] refBus,
  output logic [NUM_SIG-1:0] testVec,
  output logic               lastPos,
  output logic               mismatch
);

  localparam logic [NUM_SIG-1:0] FIRST_VEC = NUM_SIG'(1);

  logic [NUM_SIG-1:0] walkVec;
  logic [NUM_SIG-1:0] sideA;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      walkVec <= '0;
    end else if (strobe.load) begin
      walkVec <= FIRST_VEC;
    end else if (strobe.clear) begin
      walkVec <= '0;
    end else if (strobe.advance) begin
      walkVec <= {walkVec[NUM_SIG-2:0], 1'b0};
    end
  end

  // Fault injection into the live side only
  assign sideA   = liveBus ^ walkVec;
  assign testVec = walkVec;
  assign lastPos = walkVec[NUM_SIG-1];

  mst_compare #(.NUM_SIG(NUM_SIG)) u_cmp (
    .sideA    (sideA),
    .sideB    (refBus),
    .mismatch (mismatch)
  );

endmodule

// File: rtl/mst_control.sv
module mst_control
  import mst_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       clrErr,
  input  logic       mismatch,
  input  logic       lastPos,
  output mstStrobe_t strobe,
  output logic       busy,
  output logic       done,
  output logic       errPulse,
  output logic       stErr
);

  mstState_e state;
  mstState_e stateNext;
  logic      inRun;
  logic      failHere;
  logic      finish;

  assign inRun    = (state == ST_RUN);
  assign failHere = inRun & ~mismatch;
  assign finish   = inRun & (~mismatch | lastPos);

  always_comb begin
    strobe.load    = ~inRun & start;
    strobe.advance = inRun & mismatch & ~lastPos;
    strobe.clear   = finish;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start)  stateNext = ST_RUN;
      ST_RUN:  if (finish) stateNext = ST_IDLE;
      default:             stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      done     <= 1'b0;
      errPulse <= 1'b0;
      stErr    <= 1'b0;
    end else begin
      state    <= stateNext;
      done     <= finish;
      errPulse <= failHere;
      stErr    <= failHere | (stErr & ~clrErr);
    end
  end

  assign busy = inRun;

endmodule

// File: rtl/mismatch_selftest.sv
module mismatch_selftest
  import mst_pkg::*;
#(
  parameter int NUM_SIG = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               clrErr,
  input  logic [NUM_SIG-1:0] liveBus,
  input  logic [NUM_SIG-1:0] refBus,
  output logic [NUM_SIG-1:0] testVec,
  output logic               mismatch,
  output logic               busy,
  output logic               done,
  output logic               stErr,
  output logic               errPulse
);

  mstStrobe_t strobe;
  logic       lastPos;

  mst_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .clrErr   (clrErr),
    .mismatch (mismatch),
    .lastPos  (lastPos),
    .strobe   (strobe),
    .busy     (busy),
    .done     (done),
    .errPulse (errPulse),
    .stErr    (stErr)
  );

  mst_datapath #(.NUM_SIG(NUM_SIG)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .liveBus  (liveBus),
    .refBus   (refBus),
    .testVec  (testVec),
    .lastPos  (lastPos),
    .mismatch (mismatch)
  );

endmodule

// File: rtl/mst_checker.sv
module mst_checker #(
  parameter int NUM_SIG = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               clrErr,
  input logic [NUM_SIG-1:0] testVec,
  input logic               mismatch,
  input logic               busy,
  input logic               done,
  input logic               stErr,
  input logic               errPulse
);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> ($countones(testVec) == 1));

  p_first_pos_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (testVec == NUM_SIG'(1)));

  p_walk_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (testVec == NUM_SIG'($past(testVec) << 1)));

  p_stop_on_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !mismatch) |=> (!busy && errPulse && stErr && done));

  p_err_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |=> !errPulse);

  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (testVec == '0));

  p_done_one_cycle_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stErr && !clrErr) |=> stErr);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    clrErr |=> (errPulse || !stErr));

endmodule

bind mismatch_selftest mst_checker #(.NUM_SIG(NUM_SIG)) u_mstChk (
  .clk      (clk),
  .rstN     (rstN),
  .clrErr   (clrErr),
  .testVec  (testVec),
  .mismatch (mismatch),
  .busy     (busy),
  .done     (done),
  .stErr    (stErr),
  .errPulse (errPulse)
);

// File: tb/mismatch_selftest_bench.sv
module mismatch_selftest_bench;

  localparam int NS = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          clrErr = 1'b0;
  logic [NS-1:0] liveBus = '0;
  logic [NS-1:0] refBus = '0;
  logic [NS-1:0] testVec;
  logic          mismatch, busy, done, stErr, errPulse;

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  // behavioural reference state
  int mBusy = 0, mPos = 0, mErr = 0, mDone = 0, mPulse = 0;
  logic [NS-1:0] mVec;
  logic          mMm;
  int            mSet;

  always #2 clk = ~clk;

  mismatch_selftest u_mismatch_selftest (
    .clk(clk), .rstN(rstN), .start(start), .clrErr(clrErr),
    .liveBus(liveBus), .refBus(refBus), .testVec(testVec),
    .mismatch(mismatch), .busy(busy), .done(done),
    .stErr(stErr), .errPulse(errPulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // reference model advances on every edge
  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mPos = 0; mErr = 0; mDone = 0; mPulse = 0;
    end else begin
      mVec = (mBusy != 0) ? NS'(1 << mPos) : '0;
      mMm  = ((liveBus ^ mVec) != refBus);
      mDone = 0; mPulse = 0; mSet = 0;
      if (mBusy != 0) begin
        if (!mMm) begin
          mBusy = 0; mDone = 1; mPulse = 1; mSet = 1;
        end else if (mPos == NS - 1) begin
          mBusy = 0; mDone = 1;
        end else begin
          mPos++;
        end
      end else if (start) begin
        mBusy = 1; mPos = 0;
      end
      mErr = ((mSet != 0) || ((mErr != 0) && !clrErr)) ? 1 : 0;
    end
  end

  // compare every output on every cycle, away from the edge
  always @(negedge clk) begin
    if (!finished) begin
      logic [NS-1:0] eVec;
      eVec = (mBusy != 0) ? NS'(1 << mPos) : '0;
      chk("R3/R4/R7", "testVec", int'(testVec), int'(eVec));
      chk("R1", "mismatch", int'(mismatch), int'((liveBus ^ eVec) != refBus));
      chk("R2", "busy", int'(busy), mBusy);
      chk("R8", "done", int'(done), mDone);
      chk("R5", "errPulse", int'(errPulse), mPulse);
      chk("R9", "stErr", int'(stErr), mErr);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  // launches a run; extraAt>=0 pulses start again at that busy cycle
  task automatic launch(input int extraAt, input bit clrDuring, output int runLen);
    @(posedge clk); #1;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    runLen = 0;
    while (busy && runLen < 20) begin
      start  = (runLen == extraAt);
      clrErr = clrDuring;
      runLen++;
      @(posedge clk); #1;
    end
    start  = 1'b0;
    clrErr = 1'b0;
  endtask

  initial begin
    int len;
    step(3);
    chk("R11", "reset busy", int'(busy), 0);
    chk("R11", "reset stErr", int'(stErr), 0);
    chk("R11", "reset testVec", int'(testVec), 0);
    rstN = 1'b1;
    step(2);

    // R7 and R1: idle monitoring sees live differences only
    liveBus = 6'b000100; step(1);
    chk("R7", "idle vec", int'(testVec), 0);
    chk("R1", "idle mismatch", int'(mismatch), 1);
    liveBus = '0; step(1);
    chk("R1", "idle match", int'(mismatch), 0);

    // clean run
    launch(-1, 1'b0, len);
    chk("R2", "clean run length", len, 6);
    chk("R8", "done after clean run", int'(done), 1);
    chk("R6", "no error after clean run", int'(stErr), 0);
    chk("R6", "no pulse after clean run", int'(errPulse), 0);
    step(2);

    // R10: start during run ignored
    launch(2, 1'b0, len);
    chk("R10", "run length with mid-run start", len, 6);
    step(1);
    chk("R10", "no relaunch", int'(busy), 0);
    step(2);

    // stuck comparator emulated at positions 3, 0, 5
    refBus = 6'b001000;
    launch(-1, 1'b0, len);
    chk("R5", "early stop at position 3", len, 4);
    chk("R5", "error pulse", int'(errPulse), 1);
    chk("R8", "done on early stop", int'(done), 1);
    step(1);
    chk("R5", "pulse single", int'(errPulse), 0);
    refBus = '0;
    step(3);
    chk("R9", "sticky while idle", int'(stErr), 1);

    launch(-1, 1'b0, len);
    chk("R6", "clean run keeps flag", int'(stErr), 1);
    clrErr = 1'b1; step(1); clrErr = 1'b0;
    chk("R9", "clear", int'(stErr), 0);

    refBus = 6'b000001;
    launch(-1, 1'b0, len);
    chk("R5", "early stop at position 0", len, 1);
    refBus = '0; clrErr = 1'b1; step(1); clrErr = 1'b0;

    refBus = 6'b100000;
    launch(-1, 1'b0, len);
    chk("R5", "stop at position 5", len, 6);
    chk("R5", "error on last", int'(stErr), 1);
    refBus = '0; clrErr = 1'b1; step(1); clrErr = 1'b0;

    // R9: set and clear at the same edge, set wins
    refBus = 6'b000100;
    launch(-1, 1'b1, len);
    chk("R9", "set beats clear", int'(stErr), 1);
    refBus = '0;
    step(2);

    // R1 during a run with nonzero live bits
    liveBus = 6'b000010;
    launch(-1, 1'b0, len);
    chk("R5", "live bit cancels pattern 1", len, 2);
    liveBus = '0;
    step(3);

    finished = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

endmodule